// File: doc/BRIEF.md
# Load Data Aligner and Merger

This block sits between the read port of a data memory and the register writeback stage. Each cycle it may accept one load. A load carries a 32-bit memory word that is aligned to a word boundary, the two low bits of the byte address, the value the destination register holds now, and a 6-bit load code. From these it forms the value to write back. Byte and halfword loads are taken from the lane that the address picks, then sign-extended or zero-extended. A word load passes the memory word through unchanged. The two partial-word loads shift the memory word and merge it with the bytes of the old register value that they keep.

The result and its flags are registered. They appear one clock after the load is presented, together with a valid strobe. A halfword or word load whose address does not suit its width raises a misalignment flag. The data output still carries the lane-selected value, so the decision to trap is left to the stage that consumes the result. Lane numbering follows an endianness parameter, and the default is big-endian.

Top module: `ldal_load_align`

## Requirements
- R1: The load code is decoded as follows. 0x20 is a signed byte, 0x21 a signed halfword, 0x22 a merge-high partial load, 0x23 a word, 0x24 an unsigned byte, 0x25 an unsigned halfword and 0x26 a merge-low partial load.
- R2: A signed byte load returns the addressed byte sign-extended to 32 bits. With big-endian lanes, offset b selects memory bits [31-8b:24-8b].
- R3: An unsigned byte load returns the same addressed byte with the upper 24 bits cleared.
- R4: A halfword load selects its lane using address bit 1 only. With big-endian lanes, bit 1 = 0 selects bits [31:16] and bit 1 = 1 selects bits [15:0]. Code 0x21 sign-extends the halfword and code 0x25 zero-extends it.
- R5: A word load returns the memory word unchanged at every offset.
- R6: Merge-high at big-endian offset b returns (mem << 8b) OR (old AND ((1 << 8b) - 1)). Offset 0 therefore returns the whole memory word.
- R7: Merge-low at big-endian offset b, with s = 8(3-b), returns (mem >> s) OR (old with only its top s bits kept). Offset 3 therefore returns the whole memory word.
- R8: The misalignment flag is 1 for a halfword load with address bit 0 set and for a word load with either low address bit set. In every other case it is 0, including both partial loads at every offset.
- R9: Any other load code returns the old register value unchanged, with the misalignment flag at 0.
- R10: For every accepted load, out_vld, out_data and out_misal take their new values at the first rising edge after in_vld is sampled high.
- R11: In a cycle where in_vld is low, out_vld falls to 0 and out_data and out_misal keep their last values.
- R12: After a synchronous reset, out_vld, out_data and out_misal are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | A load is presented this cycle |
| ld_op | input | 6 | Load code |
| addr_lo | input | 2 | Byte offset within the word |
| mem_word | input | 32 | Aligned word read from memory |
| reg_old | input | 32 | Current value of the destination register |
| out_vld | output | 1 | Writeback value is valid |
| out_data | output | 32 | Value to write back |
| out_misal | output | 1 | Halfword or word load is misaligned |

## Verification
A lane index derived from the wrong address bit, or with the endianness flipped, shows up on out_data one clock after the load. It appears as a byte taken from the mirror lane, or as a merge boundary shifted by whole bytes. A wrong extension kind corrupts only the upper bits, and only when the selected lane's top bit is 1, so the sweep uses data whose lanes have their top bits both set and clear. A stale or unreset output register shows up as out_vld high in a cycle with no load, or as out_data moving while out_vld is low, and both appear on the very next cycle.

// File: rtl/ldal_pkg.sv
// Package: shared constants, load-code encoding and decoded control type for
// the load aligner. Assumes a byte-addressed word of WORD_W bits.
package ldal_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int OFF_W  = $clog2(LANES);
    localparam int OP_W   = 6;

    // Load codes; the values are decoded by the neighbouring decode stage.
    localparam logic [OP_W-1:0] CODE_S8   = 6'h20;
    localparam logic [OP_W-1:0] CODE_S16  = 6'h21;
    localparam logic [OP_W-1:0] CODE_MHI  = 6'h22;
    localparam logic [OP_W-1:0] CODE_W32  = 6'h23;
    localparam logic [OP_W-1:0] CODE_U8   = 6'h24;
    localparam logic [OP_W-1:0] CODE_U16  = 6'h25;
    localparam logic [OP_W-1:0] CODE_MLO  = 6'h26;

    typedef enum logic [2:0] {
        KIND_NONE = 3'd0,
        KIND_BYTE = 3'd1,
        KIND_HALF = 3'd2,
        KIND_WORD = 3'd3,
        KIND_MHI  = 3'd4,
        KIND_MLO  = 3'd5
    } ld_kind_e;

    typedef struct packed {
        ld_kind_e kind;
        logic     sgn;
    } ld_ctl_t;

    // Map a raw load code to its access kind and extension sign.
    function automatic ld_ctl_t decode_op(input logic [OP_W-1:0] code);
        ld_ctl_t c;
        c.kind = KIND_NONE;
        c.sgn  = 1'b0;
        unique case (code)
            CODE_S8:  begin c.kind = KIND_BYTE; c.sgn = 1'b1; end
            CODE_U8:  begin c.kind = KIND_BYTE; c.sgn = 1'b0; end
            CODE_S16: begin c.kind = KIND_HALF; c.sgn = 1'b1; end
            CODE_U16: begin c.kind = KIND_HALF; c.sgn = 1'b0; end
            CODE_W32: c.kind = KIND_WORD;
            CODE_MHI: c.kind = KIND_MHI;
            CODE_MLO: c.kind = KIND_MLO;
            default:  c.kind = KIND_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ldal_lane_pick.sv
// Module: ldal_lane_pick
// Picks a byte or halfword lane out of the aligned word and extends it to the
// full word width. Assumes the word holds an even number of byte lanes. Lane
// numbering follows BIG_END: when it is set, offset 0 is the most significant
// byte.
module ldal_lane_pick #(
    parameter int WORD_W  = 32,
    parameter int BYTE_W  = 8,
    parameter bit BIG_END = 1'b1,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int OFF_W  = $clog2(LANES),
    localparam int HALF_W = 2 * BYTE_W,
    localparam int HALVES = LANES / 2
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              sgn_i,
    output logic [WORD_W-1:0] byte_o,
    output logic [WORD_W-1:0] half_o
);

    logic [BYTE_W-1:0] lane_b [LANES];
    logic [HALF_W-1:0] lane_h [HALVES];

    // Slice the word into byte lanes and halfword lanes.
    for (genvar gi = 0; gi < LANES; gi++) begin : g_byte
        assign lane_b[gi] = word_i[gi*BYTE_W +: BYTE_W];
    end
    for (genvar gh = 0; gh < HALVES; gh++) begin : g_half
        assign lane_h[gh] = word_i[gh*HALF_W +: HALF_W];
    end

    logic [OFF_W-1:0]   b_idx;
    logic [OFF_W-2:0]   h_off;
    logic [OFF_W-2:0]   h_idx;
    logic [BYTE_W-1:0]  b_sel;
    logic [HALF_W-1:0]  h_sel;

    // Turn the address offset into physical lane indices.
    always_comb begin
        h_off = off_i[OFF_W-1:1];
        if (BIG_END) begin
            b_idx = OFF_W'(LANES - 1) - off_i;
            h_idx = (OFF_W-1)'(HALVES - 1) - h_off;
        end else begin
            b_idx = off_i;
            h_idx = h_off;
        end
    end

    // Select the lanes and extend them with the sign bit or with zeros.
    always_comb begin
        b_sel  = lane_b[b_idx];
        h_sel  = lane_h[h_idx];
        byte_o = {{(WORD_W-BYTE_W){sgn_i & b_sel[BYTE_W-1]}}, b_sel};
        half_o = {{(WORD_W-HALF_W){sgn_i & h_sel[HALF_W-1]}}, h_sel};
    end

endmodule

// File: rtl/ldal_merge.sv
// Module: ldal_merge
// Builds both partial-load results. Merge-high shifts memory up and keeps the
// low bytes of the old register. Merge-low shifts memory down and keeps the
// high bytes of the old register. Assumes the offset is a byte offset inside
// one word. With BIG_END set, the offset is mirrored into the little-end lane
// index before the shift amounts are formed.
module ldal_merge #(
    parameter int WORD_W  = 32,
    parameter int BYTE_W  = 8,
    parameter bit BIG_END = 1'b1,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int OFF_W  = $clog2(LANES),
    localparam int SH_W   = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] mem_i,
    input  logic [WORD_W-1:0] old_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [WORD_W-1:0] hi_o,
    output logic [WORD_W-1:0] lo_o
);

    logic [OFF_W-1:0]  lane_k;
    logic [SH_W-1:0]   sh_hi;
    logic [SH_W-1:0]   sh_lo;
    logic [WORD_W-1:0] keep_lo;
    logic [WORD_W-1:0] keep_hi;

    // Derive the lane index and the two shift distances.
    always_comb begin
        lane_k = BIG_END ? (OFF_W'(LANES - 1) - off_i) : off_i;
        sh_hi  = SH_W'((LANES - 1 - int'(lane_k)) * BYTE_W);
        sh_lo  = SH_W'(int'(lane_k) * BYTE_W);
    end

    // Form the masks of the old register bits that survive each merge.
    always_comb begin
        keep_lo = ~({WORD_W{1'b1}} << sh_hi);
        keep_hi = ~({WORD_W{1'b1}} >> sh_lo);
    end

    // Combine the shifted memory word with the bytes of the old register.
    always_comb begin
        hi_o = (mem_i << sh_hi) | (old_i & keep_lo);
        lo_o = (mem_i >> sh_lo) | (old_i & keep_hi);
    end

endmodule

// File: rtl/ldal_align_chk.sv
// Module: ldal_align_chk
// Raises the misalignment flag for halfword and word accesses whose offset is
// not a multiple of the access size. Byte loads, partial loads and undecoded
// codes never raise it.
module ldal_align_chk #(
    parameter int OFF_W = 2
) (
    input  ldal_pkg::ld_kind_e kind_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic               misal_o
);

    import ldal_pkg::*;

    // Check the offset against the natural alignment of the access.
    always_comb begin
        unique case (kind_i)
            KIND_HALF: misal_o = off_i[0];
            KIND_WORD: misal_o = |off_i;
            default:   misal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldal_load_align.sv
// Module: ldal_load_align (top)
// Load aligner between the memory read port and writeback. It decodes the
// load code, chooses the lane result, merge result, full word or old value,
// and registers the result with a valid strobe and a misalignment flag.
// Assumes one load per cycle at most and no back-pressure. Reset is
// synchronous and active low.
module ldal_load_align #(
    parameter int WORD_W  = ldal_pkg::WORD_W,
    parameter int BYTE_W  = ldal_pkg::BYTE_W,
    parameter bit BIG_END = 1'b1,
    localparam int LANES  = WORD_W / BYTE_W,
    localparam int OFF_W  = $clog2(LANES),
    localparam int OP_W   = ldal_pkg::OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [WORD_W-1:0] reg_old,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_data,
    output logic              out_misal
);

    import ldal_pkg::*;

    ld_ctl_t           ctl;
    logic [WORD_W-1:0] byte_res;
    logic [WORD_W-1:0] half_res;
    logic [WORD_W-1:0] mhi_res;
    logic [WORD_W-1:0] mlo_res;
    logic [WORD_W-1:0] data_nx;
    logic              misal_nx;
    ld_kind_e          kind_q;
    logic              sgn_q;

    // Decode the load code into an access kind and sign.
    always_comb ctl = decode_op(ld_op);

    ldal_lane_pick #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .BIG_END(BIG_END)
    ) u_pick (
        .word_i(mem_word),
        .off_i (addr_lo),
        .sgn_i (ctl.sgn),
        .byte_o(byte_res),
        .half_o(half_res)
    );

    ldal_merge #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .BIG_END(BIG_END)
    ) u_merge (
        .mem_i(mem_word),
        .old_i(reg_old),
        .off_i(addr_lo),
        .hi_o (mhi_res),
        .lo_o (mlo_res)
    );

    ldal_align_chk #(
        .OFF_W(OFF_W)
    ) u_chk (
        .kind_i (ctl.kind),
        .off_i  (addr_lo),
        .misal_o(misal_nx)
    );

    // Choose the writeback value for the decoded kind.
    always_comb begin
        unique case (ctl.kind)
            KIND_BYTE: data_nx = byte_res;
            KIND_HALF: data_nx = half_res;
            KIND_WORD: data_nx = mem_word;
            KIND_MHI:  data_nx = mhi_res;
            KIND_MLO:  data_nx = mlo_res;
            default:   data_nx = reg_old;
        endcase
    end

    // Register the result; hold the data and flag in cycles without a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_data  <= '0;
            out_misal <= 1'b0;
            kind_q    <= KIND_NONE;
            sgn_q     <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_data  <= data_nx;
                out_misal <= misal_nx;
                kind_q    <= ctl.kind;
                sgn_q     <= ctl.sgn;
            end
        end
    end

    // A word load delivers the memory word unmodified.
    AST_WORD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ld_op == CODE_W32) |=> (out_data == $past(mem_word))); // R5

    // Unsigned byte results carry no bits above the byte.
    AST_U8_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && kind_q == KIND_BYTE && !sgn_q)
            |-> (out_data[WORD_W-1:BYTE_W] == '0)); // R3

    // Signed byte results have uniform upper bits.
    AST_S8_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && kind_q == KIND_BYTE && sgn_q)
            |-> ($countones(out_data[WORD_W-1:BYTE_W-1]) == 0
                 || $countones(out_data[WORD_W-1:BYTE_W-1]) == WORD_W-BYTE_W+1)); // R2

    // Partial loads never raise the misalignment flag.
    AST_MERGE_NO_MISAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (ld_op == CODE_MHI || ld_op == CODE_MLO)) |=> !out_misal); // R8

    // Undecoded codes hand back the old register value.
    AST_UNKNOWN_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && ctl.kind == KIND_NONE) |=> (out_data == $past(reg_old))); // R9

    // Without a load, the data output does not move.
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_vld && $past(rst_n)) |=> ($stable(out_data) && !out_vld)); // R11

endmodule

// File: tb/ldal_load_align_test.sv
// Bench: sweeps every load code and offset over several data patterns, with
// big-endian lanes. Expected values come from arithmetic on the address.
module ldal_load_align_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [5:0]  ld_op = '0;
    logic [1:0]  addr_lo = '0;
    logic [31:0] mem_word = '0;
    logic [31:0] reg_old = '0;
    logic        out_vld;
    logic [31:0] out_data;
    logic        out_misal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ldal_load_align uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .ld_op(ld_op),
        .addr_lo(addr_lo), .mem_word(mem_word), .reg_old(reg_old),
        .out_vld(out_vld), .out_data(out_data), .out_misal(out_misal)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h op=%h off=%0d mem=%h old=%h",
                     req, got, exp, ld_op, addr_lo, mem_word, reg_old);
        end
    endtask

    // Expected writeback value, big-endian: offset b means byte at shift 8*(3-b).
    function automatic logic [31:0] model_data(input logic [5:0] op, input logic [1:0] b,
                                               input logic [31:0] m, input logic [31:0] o);
        logic [7:0]  by;
        logic [15:0] hw;
        int s;
        by = 8'((m >> (8 * (3 - int'(b)))) & 32'hFF);
        hw = 16'((m >> (b[1] ? 0 : 16)) & 32'hFFFF);
        s  = 8 * (3 - int'(b));
        case (op)
            6'h20: return {{24{by[7]}}, by};                       // R2
            6'h24: return {24'h0, by};                             // R3
            6'h21: return {{16{hw[15]}}, hw};                      // R4
            6'h25: return {16'h0, hw};                             // R4
            6'h23: return m;                                       // R5
            6'h22: return (m << (8 * int'(b))) | (o & ((32'h1 << (8 * int'(b))) - 32'h1)); // R6
            6'h26: return (m >> s) | (o & ~(32'hFFFF_FFFF >> s));  // R7
            default: return o;                                     // R9
        endcase
    endfunction

    function automatic logic model_misal(input logic [5:0] op, input logic [1:0] b);
        if (op == 6'h21 || op == 6'h25) return b[0];
        if (op == 6'h23) return b != 2'd0;
        return 1'b0;
    endfunction

    task automatic one_load(input logic [5:0] op, input logic [1:0] b,
                            input logic [31:0] m, input logic [31:0] o);
        @(negedge clk);
        in_vld = 1'b1; ld_op = op; addr_lo = b; mem_word = m; reg_old = o;
        @(negedge clk);
        check("R10 out_vld", {31'h0, out_vld}, 32'h1);
        check("R1 data", out_data, model_data(op, b, m, o));
        check("R8 misal", {31'h0, out_misal}, {31'h0, model_misal(op, b)});
        in_vld = 1'b0;
    endtask

    initial begin
        logic [31:0] pats [4];
        logic [5:0]  ops  [9];
        logic [31:0] held;
        logic        held_m;
        pats[0] = 32'h80FF_7F01; pats[1] = 32'h1234_5678;
        pats[2] = 32'hFEDC_BA98; pats[3] = 32'h7F80_01FE;
        ops[0] = 6'h20; ops[1] = 6'h21; ops[2] = 6'h22; ops[3] = 6'h23;
        ops[4] = 6'h24; ops[5] = 6'h25; ops[6] = 6'h26; ops[7] = 6'h27; ops[8] = 6'h00;

        repeat (3) @(negedge clk);
        check("R12 vld", {31'h0, out_vld}, 32'h0);
        check("R12 data", out_data, 32'h0);
        check("R12 misal", {31'h0, out_misal}, 32'h0);
        rst_n = 1'b1;

        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 9; k++) begin
                for (int b = 0; b < 4; b++) begin
                    one_load(ops[k], 2'(b), pats[p], ~pats[p] ^ 32'hA55A_3CC3);
                end
            end
        end

        // R6/R7 corner: full-word merges at the boundary offsets.
        one_load(6'h22, 2'd0, 32'hCAFE_F00D, 32'h1111_1111);
        check("R6 full", out_data, 32'hCAFE_F00D);
        one_load(6'h26, 2'd3, 32'hCAFE_F00D, 32'h1111_1111);
        check("R7 full", out_data, 32'hCAFE_F00D);

        // R11: idle cycles change neither data nor flag, and drop valid.
        one_load(6'h23, 2'd1, 32'hDEAD_BEEF, 32'h0);
        held = out_data; held_m = out_misal;
        mem_word = 32'h0; ld_op = 6'h20; addr_lo = 2'd0;
        @(negedge clk);
        check("R11 vld", {31'h0, out_vld}, 32'h0);
        check("R11 data", out_data, held);
        check("R11 misal", {31'h0, out_misal}, {31'h0, held_m});

        // R10: back-to-back loads each appear one edge later.
        @(negedge clk);
        in_vld = 1'b1; ld_op = 6'h24; addr_lo = 2'd2; mem_word = 32'h0011_2233;
        @(negedge clk);
        check("R10 b2b first", out_data, 32'h0000_0022);
        ld_op = 6'h20; addr_lo = 2'd0; mem_word = 32'h9900_0000;
        @(negedge clk);
        check("R10 b2b second", out_data, 32'hFFFF_FF99);
        in_vld = 1'b0;

        // R12: reset in mid-run clears the outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 rerun data", out_data, 32'h0);
        check("R12 rerun vld", {31'h0, out_vld}, 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R10 got=hung exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule